// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a simple word-addressed register bus. Word addresses below 0x400 form a data window. In that window, address bits [9:2] act as a per-pin select, with bit n+2 choosing pin n. A single write therefore changes only the chosen output pins. Independent software drivers can each update their own pins in one transaction, with no read-modify-write sequence and no risk of undoing a neighbour's change.

Reads through the window use the same selection and report only the chosen pins. For a pin configured as output, the read returns the output latch. For a pin configured as input, it returns the pad level after a two-flop synchronizer. A direction register at offset 0x400 sits outside the window and is always written and read in full. The bus takes one access per cycle and returns read data, with a valid flag, one cycle later. The pad drivers come straight from registers.

Top module: `gpio_addr_mask_port`

## Requirements
- R1: While reset is high and after it falls, pad_out, pad_oe, bus_rdata and bus_rvalid are all 0, so every pin is an input with its latch low.
- R2: A write with bus_addr[11:10] = 0 loads bus_wdata[n] into output latch bit n only when bus_addr[n+2] is 1. Every other latch bit is unchanged. pad_out shows the latch one cycle after the write.
- R3: A read with bus_addr[11:10] = 0 returns 0 in bus_rdata bit n when bus_addr[n+2] is 0. Bits [31:8] of bus_rdata are always 0.
- R4: In a data-window read, a selected bit returns the output latch when its pad_oe bit is 1, and the synchronized pad_in bit when its pad_oe bit is 0.
- R5: The direction register sits at word address 0x400, drives pad_oe and reads back in bits [7:0]. Writes to it and reads from it ignore the address mask.
- R6: Address bits [1:0] have no effect on any access.
- R7: A change on pad_in first appears in a read that the bus samples two clock edges after the change. Reads sampled at the first and second edges still return the old level.
- R8: bus_rvalid is 1 in the cycle after a read is sampled, and 0 in the cycle after a write or an idle cycle.
- R9: A write to any word other than the data window and 0x400 changes nothing. A read from such a word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Output latch driven to the pads |
| pad_oe | output | 8 | Per-pin output enable, the direction register |

## Verification
The hardest case to reach from the ports is a read of mixed directions, where both the output latch and the synchronized pad feed the same read word under a partial mask. Reaching it needs the direction register set to a split pattern, a latch value built up by several overlapping masked writes, and pad levels that differ from the latch, all held long enough for the synchronizer to settle. The stimulus table follows exactly that order. It then flips the direction split and repeats the read, so each pin is checked from both of its sources. A directed sequence changes pad_in in the same cycle as back-to-back reads, to pin down the edge at which the new level first appears.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } gpio_acc_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int AW       = 12,
  parameter int NPIN     = 8,
  parameter int MASK_LSB = 2,
  parameter int DIR_OFF  = 'h400
) (
  input  logic [AW-1:0]   addr,
  output gpio_acc_e       acc,
  output logic [NPIN-1:0] pin_sel
);
  localparam int WIN_HI   = MASK_LSB + NPIN;
  localparam int DIR_WORD = DIR_OFF >> MASK_LSB;

  logic win_hit;
  logic dir_hit;
  logic unused_low;

  assign unused_low = ^addr[MASK_LSB-1:0];
  assign win_hit    = (addr[AW-1:WIN_HI] == '0);
  assign dir_hit    = (addr[AW-1:MASK_LSB] == DIR_WORD[AW-MASK_LSB-1:0]);
  assign pin_sel    = addr[WIN_HI-1:MASK_LSB];

  always_comb begin
    if (win_hit)      acc = ACC_DATA;
    else if (dir_hit) acc = ACC_DIR;
    else              acc = ACC_NONE;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  gpio_acc_e       acc,
  input  logic [NPIN-1:0] pin_sel,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] latch_q,
  output logic [NPIN-1:0] dir_q
);
  genvar p;
  generate
    for (p = 0; p < NPIN; p++) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst)
          latch_q[p] <= 1'b0;
        else if (wr_en && acc == ACC_DATA && pin_sel[p])
          latch_q[p] <= wdata[p];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      dir_q <= '0;
    else if (wr_en && acc == ACC_DIR)
      dir_q <= wdata;
  end
endmodule

// File: rtl/gpio_addr_mask_port.sv
module gpio_addr_mask_port
  import gpio_pkg::*;
#(
  parameter int AW          = 12,
  parameter int DW          = 32,
  parameter int NPIN        = 8,
  parameter int MASK_LSB    = 2,
  parameter int DIR_OFF     = 'h400,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_rvalid,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  localparam int PAD_W = DW - NPIN;

  gpio_acc_e       acc;
  logic [NPIN-1:0] pin_sel;
  logic [NPIN-1:0] pad_sync;
  logic [NPIN-1:0] latch_q;
  logic [NPIN-1:0] dir_q;
  logic [NPIN-1:0] rd_pins;
  logic            wr_en;
  logic            rd_en;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata[DW-1:NPIN];
  assign wr_en = bus_valid && bus_write;
  assign rd_en = bus_valid && !bus_write;

  gpio_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_decode #(.AW(AW), .NPIN(NPIN), .MASK_LSB(MASK_LSB), .DIR_OFF(DIR_OFF)) u_decode (
    .addr    (bus_addr),
    .acc     (acc),
    .pin_sel (pin_sel)
  );

  gpio_regs #(.NPIN(NPIN)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .acc     (acc),
    .pin_sel (pin_sel),
    .wdata   (bus_wdata[NPIN-1:0]),
    .latch_q (latch_q),
    .dir_q   (dir_q)
  );

  always_comb begin
    case (acc)
      ACC_DATA: rd_pins = pin_sel & ((dir_q & latch_q) | (~dir_q & pad_sync));
      ACC_DIR:  rd_pins = dir_q;
      default:  rd_pins = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      bus_rdata  <= rd_en ? {{PAD_W{1'b0}}, rd_pins} : '0;
    end
  end

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_addr_mask_port_chk.sv
module gpio_addr_mask_port_chk #(
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int NPIN     = 8,
  parameter int MASK_LSB = 2,
  parameter int DIR_OFF  = 'h400
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic            bus_rvalid,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe
);
  localparam int WIN_HI = MASK_LSB + NPIN;

  logic [NPIN-1:0] sel;
  logic            in_win;
  logic            at_dir;
  assign sel    = bus_addr[WIN_HI-1:MASK_LSB];
  assign in_win = (bus_addr[AW-1:WIN_HI] == '0);
  assign at_dir = (bus_addr[AW-1:MASK_LSB] == (AW-MASK_LSB)'(DIR_OFF >> MASK_LSB));

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (pad_out == '0 && pad_oe == '0 && !bus_rvalid && bus_rdata == '0)); // R1

  AST_UNSEL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && in_win) |=>
      (((pad_out ^ $past(pad_out)) & ~$past(sel)) == '0)); // R2

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && in_win) |=>
      (((pad_out ^ $past(bus_wdata[NPIN-1:0])) & $past(sel)) == '0)); // R2

  AST_RD_UNSEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && in_win) |=>
      ((bus_rdata & ~{{(DW-NPIN){1'b0}}, $past(sel)}) == '0)); // R3

  AST_RVALID_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid); // R8

  AST_RVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !bus_rvalid); // R8

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write && at_dir) |=> $stable(pad_oe)); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write && in_win) |=> $stable(pad_out)); // R9
endmodule

bind gpio_addr_mask_port gpio_addr_mask_port_chk #(
  .AW(AW), .DW(DW), .NPIN(NPIN), .MASK_LSB(MASK_LSB), .DIR_OFF(DIR_OFF)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe)
);

// File: tb/gpio_addr_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_addr_mask_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_addr_mask_port u_gpio_addr_mask_port (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // fields: {req[3:0], chk[1:0], wr, addr[11:0], wdata[7:0], pad[7:0], exp[7:0]}
  // chk: 0 = pad_out, 1 = bus_rdata, 2 = pad_oe
  localparam int NVEC = 13;
  localparam logic [42:0] VEC [NVEC] = '{
    {4'd5, 2'd2, 1'b1, 12'h400, 8'h0F, 8'h00, 8'h0F}, // R5 set low nibble as outputs
    {4'd2, 2'd0, 1'b1, 12'h3FC, 8'hA5, 8'h00, 8'hA5}, // R2 full mask
    {4'd2, 2'd0, 1'b1, 12'h03C, 8'h00, 8'h00, 8'hA0}, // R2 low nibble only
    {4'd2, 2'd0, 1'b1, 12'h204, 8'hFF, 8'h00, 8'hA1}, // R2 pins 7 and 0
    {4'd2, 2'd0, 1'b1, 12'h000, 8'hFF, 8'h00, 8'hA1}, // R2 empty mask
    {4'd6, 2'd0, 1'b1, 12'h3FF, 8'h3C, 8'h00, 8'h3C}, // R6 low bits set
    {4'd4, 2'd1, 1'b0, 12'h3FC, 8'h00, 8'hF0, 8'hFC}, // R4 mixed sources
    {4'd3, 2'd1, 1'b0, 12'h154, 8'h00, 8'hF0, 8'h54}, // R3 partial read mask
    {4'd5, 2'd1, 1'b0, 12'h400, 8'h00, 8'hF0, 8'h0F}, // R5 direction readback
    {4'd9, 2'd2, 1'b1, 12'h7FC, 8'hFF, 8'hF0, 8'h0F}, // R9 unmapped write
    {4'd9, 2'd1, 1'b0, 12'h7FC, 8'h00, 8'hF0, 8'h00}, // R9 unmapped read
    {4'd6, 2'd2, 1'b1, 12'h403, 8'hF0, 8'h5A, 8'hF0}, // R6 R5 direction, low bits set
    {4'd4, 2'd1, 1'b0, 12'h3FC, 8'h00, 8'h5A, 8'h3A}  // R4 flipped split
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [7:0] d);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = {24'hFFFFFF, d};
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs held at zero in reset
    check("R1 pad_out in reset", {24'd0, pad_out}, 32'd0);
    check("R1 pad_oe in reset", {24'd0, pad_oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 32'd0);
    check("R1 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [42:0] v;
      string tag;
      v = VEC[i];
      pad_in = v[15:8];
      repeat (3) @(negedge clk);
      access(v[36], v[35:24], v[23:16]);
      tag = $sformatf("R%0d table entry %0d", v[42:39], i);
      case (v[38:37])
        2'd0:    check(tag, {24'd0, pad_out}, {24'd0, v[7:0]});
        2'd1:    check(tag, bus_rdata, {24'd0, v[7:0]});
        default: check(tag, {24'd0, pad_oe}, {24'd0, v[7:0]});
      endcase
    end

    // R8 rvalid after a read and after a write
    access(1'b0, 12'h3FC, 8'h00);
    check("R8 rvalid after read", {31'd0, bus_rvalid}, 32'd1);
    access(1'b1, 12'h000, 8'h00);
    check("R8 rvalid after write", {31'd0, bus_rvalid}, 32'd0);

    // R7 synchronizer latency: dir=F0, latch=3C, pad was 5A
    pad_in = 8'h05;
    access(1'b0, 12'h3FC, 8'h00);
    check("R7 first edge old level", bus_rdata, 32'h3A);
    access(1'b0, 12'h3FC, 8'h00);
    check("R7 second edge old level", bus_rdata, 32'h3A);
    access(1'b0, 12'h3FC, 8'h00);
    check("R7 third edge new level", bus_rdata, 32'h35);

    // R3 upper read bits zero even with all-ones write data seen earlier
    access(1'b0, 12'h3FC, 8'h00);
    check("R3 upper bits zero", {bus_rdata[31:8], 8'd0}, 32'd0);

    // R1 reset mid-run clears latch and direction
    rst = 1'b1;
    @(negedge clk);
    check("R1 pad_out after mid reset", {24'd0, pad_out}, 32'd0);
    check("R1 pad_oe after mid reset", {24'd0, pad_oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule